// File: doc/BRIEF.md
# Two-Stage SPI Clock Prescaler

This block derives the serial clock of an SPI master from a fast main clock. Division happens in two stages. A power-of-two stage, selected by a 2-bit exponent, emits one tick every 2, 4, 8 or 16 main cycles. A linear stage counts those ticks up to a 6-bit reload value and ends a half period of the serial clock each time it wraps. Alongside the serial clock level, the block produces one-cycle strobes that mark the leading and trailing edges. A shift engine uses these strobes to launch and capture data.

While the clock is idle, its level follows the polarity input. A run request starts toggling, and dropping the request lets the current half period finish before the clock returns to idle. The exponent, reload value and polarity are captured only while the clock is idle, so a running transfer always sees one consistent setting. An enable input stops the clock at once. Choosing the exponent and reload value for a target rate is left to the user of the block.

Top module: `spi_clk_prescaler`

## Requirements
- R1: One half period of `sclk_o` lasts (2 << `div_i`) * (`brg_i` + 1) main clock cycles, and a full period lasts twice that. The first leading edge appears (half period + 1) cycles after the cycle in which `run_i` is first sampled high while idle.
- R2: With `div_i`=0 and `brg_i`=4 the full period is 20 main cycles. With `div_i`=3 and `brg_i`=63 it is 2048 main cycles.
- R3: A `brg_i` value below 4 behaves exactly like 4.
- R4: While idle, `sclk_o` equals `cpol_i`. With `cpol_i`=1 the clock idles high and the leading edge drives it low.
- R5: `lead_o` is a one-cycle pulse, high in the cycle where `sclk_o` first shows the active level (not `cpol`). `trail_o` is a one-cycle pulse, high in the cycle where `sclk_o` returns to the idle level. The two are never high together.
- R6: Changes to `div_i`, `brg_i` or `cpol_i` while the clock is running have no effect until the clock has returned to idle. The next run then uses the new values.
- R7: When `run_i` goes low, the clock completes its current half period and then stays idle. A strobe is emitted only if `run_i` was high in the cycle the half period ended.
- R8: When `en_i` is low, `sclk_o` takes the idle level in the next cycle, no strobes occur and `run_i` is ignored. After re-enabling with `run_i` high, timing restarts from the beginning as in R1.
- R9: During and right after reset, `sclk_o`, `lead_o` and `trail_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; when low, forces idle at once |
| run_i | input | 1 | Run request for the serial clock |
| cpol_i | input | 1 | Idle level of the serial clock |
| div_i | input | 2 | Power-of-two stage exponent, divide by 2 << div_i |
| brg_i | input | 6 | Linear stage reload, divide by 2*(brg_i+1), clamped to at least 4 |
| sclk_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on the leading edge |
| trail_o | output | 1 | One-cycle strobe on the trailing edge |

## Verification
The bench measures edge spacing at the fastest and slowest settings, at a middle setting and at a clamped reload value. An off-by-one in either stage would shift these intervals by a tick or a whole prescaler period, and a missing clamp would give a period shorter than 20 cycles. It changes the configuration between edges of a running clock. A design that sampled the configuration continuously would stretch the very next half period instead of waiting for idle. It drops `run_i` at both clock levels and drops `en_i` in mid-transfer. A wrong stop rule would show up as a truncated half period, an extra trailing strobe or a clock left parked at the active level. The idle-high polarity case catches a design that hard-codes the rest level.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;
  parameter int unsigned DIV_W   = 2;
  parameter int unsigned BRG_W   = 6;
  parameter int unsigned BRG_MIN = 4;
endpackage

// File: rtl/spi_presc_cfg.sv
module spi_presc_cfg #(
  parameter int unsigned DIV_W   = spi_presc_pkg::DIV_W,
  parameter int unsigned BRG_W   = spi_presc_pkg::BRG_W,
  parameter int unsigned BRG_MIN = spi_presc_pkg::BRG_MIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  input  logic             cpol_i,
  output logic [DIV_W-1:0] div_o,
  output logic [BRG_W-1:0] brg_o,
  output logic             cpol_o
);
  localparam logic [BRG_W-1:0] BrgFloor = BRG_W'(BRG_MIN);

  logic [BRG_W-1:0] brg_clamped;

  assign brg_clamped = (brg_i < BrgFloor) ? BrgFloor : brg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o  <= '0;
      brg_o  <= BrgFloor;
      cpol_o <= 1'b0;
    end else if (load_i) begin
      div_o  <= div_i;
      brg_o  <= brg_clamped;
      cpol_o <= cpol_i;
    end
  end
endmodule

// File: rtl/spi_presc_pow2.sv
module spi_presc_pow2 #(
  parameter int unsigned DIV_W = spi_presc_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int unsigned PreW = 1 << DIV_W;

  logic [PreW-1:0] cnt_q;
  logic [PreW-1:0] mask;
  logic            term;

  // low (div+1) bits all ones marks the last cycle of 2<<div
  for (genvar i = 0; i < PreW; i++) begin : g_mask
    assign mask[i] = (i <= int'(div_i));
  end

  assign term   = &(cnt_q | ~mask);
  assign tick_o = term & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (term)   cnt_q <= '0;
    else             cnt_q <= cnt_q + PreW'(1);
  end
endmodule

// File: rtl/spi_presc_lin.sv
module spi_presc_lin #(
  parameter int unsigned BRG_W = spi_presc_pkg::BRG_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             wrap_o
);
  logic [BRG_W-1:0] cnt_q;

  assign wrap_o = tick_i & (cnt_q == brg_i) & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + BRG_W'(1);
  end
endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler #(
  parameter int unsigned DIV_W   = spi_presc_pkg::DIV_W,
  parameter int unsigned BRG_W   = spi_presc_pkg::BRG_W,
  parameter int unsigned BRG_MIN = spi_presc_pkg::BRG_MIN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BRG_W-1:0] brg_i,
  output logic             sclk_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic             active_q;
  logic             sclk_q, lead_q, trail_q;
  logic [DIV_W-1:0] div_q;
  logic [BRG_W-1:0] brg_q;
  logic             cpol_q;
  logic             cnt_clr, tick, half_end, at_active_lvl;

  // configuration only moves while idle
  spi_presc_cfg #(.DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~active_q),
    .div_i  (div_i),
    .brg_i  (brg_i),
    .cpol_i (cpol_i),
    .div_o  (div_q),
    .brg_o  (brg_q),
    .cpol_o (cpol_q)
  );

  assign cnt_clr = ~active_q | ~en_i;

  spi_presc_pow2 #(.DIV_W(DIV_W)) u_pow2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_presc_lin #(.BRG_W(BRG_W)) u_lin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .tick_i (tick),
    .brg_i  (brg_q),
    .wrap_o (half_end)
  );

  assign at_active_lvl = (sclk_q != cpol_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      sclk_q   <= cpol_i;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else if (!active_q) begin
      active_q <= run_i;
      sclk_q   <= cpol_i;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      if (half_end) begin
        if (at_active_lvl) begin
          sclk_q  <= cpol_q;
          trail_q <= run_i;
          if (!run_i) active_q <= 1'b0;
        end else if (run_i) begin
          sclk_q <= ~cpol_q;
          lead_q <= 1'b1;
        end else begin
          active_q <= 1'b0;
        end
      end
    end
  end

  assign sclk_o  = sclk_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;
endmodule

// File: rtl/spi_clk_prescaler_chk.sv
module spi_clk_prescaler_chk #(
  parameter int unsigned DIV_W   = spi_presc_pkg::DIV_W,
  parameter int unsigned BRG_W   = spi_presc_pkg::BRG_W,
  parameter int unsigned BRG_MIN = spi_presc_pkg::BRG_MIN
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             run_i,
  input logic             cpol_i,
  input logic             sclk_i,
  input logic             lead_i,
  input logic             trail_i,
  input logic             active_i,
  input logic [DIV_W-1:0] div_q_i,
  input logic [BRG_W-1:0] brg_q_i,
  input logic             cpol_q_i
);
  AST_LEAD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |=> !lead_i); // R5
  AST_TRAIL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_i |=> !trail_i); // R5
  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lead_i && trail_i)); // R5
  AST_STROBE_MOVES_SCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i || trail_i) |-> !$stable(sclk_i)); // R5
  AST_LEAD_ACTIVE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_i |-> (sclk_i != cpol_q_i)); // R4
  AST_STROBE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lead_i || trail_i) |-> $past(run_i)); // R7
  AST_EN_LOW_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ((sclk_i == $past(cpol_i)) && !lead_i && !trail_i)); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |->
      ($stable(div_q_i) && $stable(brg_q_i) && $stable(cpol_q_i))); // R6
  AST_BRG_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brg_q_i >= BRG_W'(BRG_MIN)); // R3
endmodule

bind spi_clk_prescaler spi_clk_prescaler_chk #(
  .DIV_W(DIV_W), .BRG_W(BRG_W), .BRG_MIN(BRG_MIN)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .run_i    (run_i),
  .cpol_i   (cpol_i),
  .sclk_i   (sclk_o),
  .lead_i   (lead_o),
  .trail_i  (trail_o),
  .active_i (active_q),
  .div_q_i  (div_q),
  .brg_q_i  (brg_q),
  .cpol_q_i (cpol_q)
);

// File: tb/tb_spi_clk_prescaler.sv
module tb_spi_clk_prescaler;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       run_i = 1'b0;
  logic       cpol_i = 1'b0;
  logic [1:0] div_i = 2'd0;
  logic [5:0] brg_i = 6'd4;
  logic       sclk_o, lead_o, trail_o;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  spi_clk_prescaler dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .run_i(run_i),
    .cpol_i(cpol_i), .div_i(div_i), .brg_i(brg_i),
    .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // waits for a strobe, returns cycle stamp; t = -1 on timeout
  task automatic wait_strobe(input bit want_lead, input int limit, output int t);
    t = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i);
      if ((want_lead && lead_o) || (!want_lead && trail_o)) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic force_idle();
    @(negedge clk_i);
    run_i = 1'b0;
    en_i  = 1'b0;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic measure(input logic [1:0] d, input logic [5:0] b, input logic pol,
                         input int h, input string tag);
    int t0, t1, t2, t3;
    @(negedge clk_i);
    div_i = d; brg_i = b; cpol_i = pol;
    @(negedge clk_i);
    run_i = 1'b1;
    t0 = cyc;
    wait_strobe(1'b1, 4 * h + 20, t1);
    check(t1 - t0 == h + 1, {tag, " first lead latency R1"}, t1 - t0, h + 1);
    check(sclk_o == ~pol, {tag, " sclk active level at lead R5"}, sclk_o, ~pol);
    @(negedge clk_i);
    check(lead_o == 1'b0, {tag, " lead one cycle R5"}, lead_o, 0);
    wait_strobe(1'b0, 4 * h + 20, t2);
    check(t2 - t1 == h, {tag, " half period R1"}, t2 - t1, h);
    check(sclk_o == pol, {tag, " sclk idle level at trail R5"}, sclk_o, pol);
    wait_strobe(1'b1, 4 * h + 20, t3);
    check(t3 - t1 == 2 * h, {tag, " full period R1"}, t3 - t1, 2 * h);
    force_idle();
  endtask

  task automatic t_reset();
    check(sclk_o == 1'b0 && lead_o == 1'b0 && trail_o == 1'b0, "reset outputs R9",
          {sclk_o, lead_o, trail_o}, 0);
  endtask

  task automatic t_fastest();  measure(2'd0, 6'd4, 1'b0, 10, "fastest R2");   endtask
  task automatic t_middle();   measure(2'd1, 6'd5, 1'b0, 24, "middle R1");    endtask
  task automatic t_clamp();    measure(2'd0, 6'd1, 1'b0, 10, "clamp R3");     endtask
  task automatic t_slowest();  measure(2'd3, 6'd63, 1'b0, 1024, "slowest R2"); endtask

  task automatic t_cpol_high();
    @(negedge clk_i);
    cpol_i = 1'b1;
    repeat (2) @(negedge clk_i);
    check(sclk_o == 1'b1, "idle high R4", sclk_o, 1);
    measure(2'd0, 6'd4, 1'b1, 10, "cpol high R4");
    cpol_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check(sclk_o == 1'b0, "idle low R4", sclk_o, 0);
  endtask

  task automatic t_cfg_frozen();
    int t0, t1, t2;
    @(negedge clk_i);
    div_i = 2'd0; brg_i = 6'd4; cpol_i = 1'b0;
    run_i = 1'b1;
    wait_strobe(1'b1, 60, t1);
    div_i = 2'd2; brg_i = 6'd20; cpol_i = 1'b1;
    wait_strobe(1'b0, 60, t2);
    check(t2 - t1 == 10, "config ignored while running R6", t2 - t1, 10);
    check(sclk_o == 1'b0, "polarity ignored while running R6", sclk_o, 0);
    run_i = 1'b0;
    repeat (30) @(negedge clk_i);
    cpol_i = 1'b0;
    @(negedge clk_i);
    run_i = 1'b1;
    t0 = cyc;
    wait_strobe(1'b1, 400, t1);
    check(t1 - t0 == 169, "new config after idle R6", t1 - t0, 169);
    force_idle();
  endtask

  task automatic t_stop_active();
    int t1, tidle, nstrobe;
    @(negedge clk_i);
    div_i = 2'd0; brg_i = 6'd4; cpol_i = 1'b0;
    run_i = 1'b1;
    wait_strobe(1'b1, 60, t1);
    run_i = 1'b0;
    tidle = -1; nstrobe = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk_i);
      if (lead_o || trail_o) nstrobe++;
      if (tidle < 0 && sclk_o == 1'b0) tidle = cyc;
    end
    check(tidle - t1 == 10, "stop finishes half period R7", tidle - t1, 10);
    check(nstrobe == 0, "no strobe after run low R7", nstrobe, 0);
    check(sclk_o == 1'b0, "stays idle after stop R7", sclk_o, 0);
  endtask

  task automatic t_stop_idle();
    int t2, nstrobe, nhigh;
    @(negedge clk_i);
    run_i = 1'b1;
    wait_strobe(1'b0, 60, t2);
    run_i = 1'b0;
    nstrobe = 0; nhigh = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (lead_o || trail_o) nstrobe++;
      if (sclk_o) nhigh++;
    end
    check(nstrobe == 0, "stop at idle level no lead R7", nstrobe, 0);
    check(nhigh == 0, "stop at idle level sclk low R7", nhigh, 0);
  endtask

  task automatic t_enable();
    int t0, t1, nstrobe;
    @(negedge clk_i);
    div_i = 2'd0; brg_i = 6'd4; cpol_i = 1'b0;
    run_i = 1'b1;
    wait_strobe(1'b1, 60, t1);
    en_i = 1'b0;
    @(negedge clk_i);
    check(sclk_o == 1'b0, "disable idles sclk next cycle R8", sclk_o, 0);
    nstrobe = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk_i);
      if (lead_o || trail_o || sclk_o) nstrobe++;
    end
    check(nstrobe == 0, "run ignored while disabled R8", nstrobe, 0);
    en_i = 1'b1;
    t0 = cyc;
    wait_strobe(1'b1, 60, t1);
    check(t1 - t0 == 11, "restart after enable R8", t1 - t0, 11);
    force_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fastest();
    t_middle();
    t_clamp();
    t_cpol_high();
    t_cfg_frozen();
    t_stop_active();
    t_stop_idle();
    t_enable();
    t_slowest();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule